// File: doc/BRIEF.md
# Pulse-Driven Phase Offset Controller

This block lives in the output-clock domain. It turns two request inputs, one to increase the phase delay and one to decrease it, into a signed phase-offset target. The target is counted in output-clock periods. Each input is first passed through a synchronizer. A request only counts as a complete low-high-low pulse, and only if the opposite input stays low for the whole of that pulse. Each accepted pulse moves the target by two periods. The target saturates at the limits of its signed range and never wraps.

A second register holds the offset that is actually applied. It follows the target one period at a time, at a pace chosen by a 2-bit bandwidth code. Every unit moved produces a one-cycle step strobe, and a busy flag shows that the applied offset has not yet reached the target. A hold input blocks request handling, so the target stays frozen while hold is high. Slewing toward a target that was already set continues during hold.

Top module: `phase_slew_ctrl`

## Requirements
- R1: After reset, `offset_o` is 0, `busy_o` is 0 and `step_o` is 0.
- R2: An accepted pulse on `inc_req_i` raises the target by exactly 2. After slewing, `offset_o` has risen by 2.
- R3: An accepted pulse on `dec_req_i` lowers the target by exactly 2. After slewing, `offset_o` has fallen by 2.
- R4: A pulse on either input is discarded if the other input is high at any sampled cycle between that pulse's rise and fall.
- R5: A request is counted only when the synchronized input falls after a sampled high phase. While the input is held high, nothing changes. A high phase that no clock edge samples is never counted.
- R6: A pulse whose fall is detected while `hold_i` is 1 is discarded. The target does not change in any cycle that follows a cycle with `hold_i` high.
- R7: With `bw_sel_i` equal to code c (0 to 3), the applied offset moves one period every 4·4^c clocks (4, 16, 64, 256). Each move raises `step_o` for exactly one cycle.
- R8: `busy_o` is 1 exactly while the applied offset differs from the target. Requests that arrive while slewing only move the target, so the final offset equals the sum of all accepted requests.
- R9: The target is a 12-bit signed value that saturates at +2047 and -2048.
- R10: Each step changes `offset_o` by exactly 1, toward the target. Between steps, `offset_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inc_req_i | input | 1 | Request to increase delay (asynchronous, active high) |
| dec_req_i | input | 1 | Request to decrease delay (asynchronous, active high) |
| hold_i | input | 1 | Hold mode: requests are ignored while high |
| bw_sel_i | input | 2 | Slew pace code: 0 fastest, 3 slowest |
| offset_o | output | 12 | Applied phase offset, signed, in output periods |
| busy_o | output | 1 | High while the applied offset differs from the target |
| step_o | output | 1 | One-cycle strobe for each unit moved |

## Verification
The assertions check the properties that hold on every cycle:
- each step moves the offset by one unit, in the direction of the target;
- the offset stays still between steps;
- a step is only taken while busy, and never on two cycles in a row;
- the target changes by at most two per cycle;
- the target stays still after a cycle with hold high.

Only the bench scenarios can show the end-to-end behaviour:
- a whole pulse is needed, and overlapping pulses cancel each other out;
- the exact spacing between steps for each bandwidth code;
- requests stack up while slewing;
- the target saturates at both ends.

// File: rtl/phase_slew_pkg.sv
package phase_slew_pkg;
  localparam int unsigned REQ_N   = 2;
  localparam int unsigned REQ_INC = 0;
  localparam int unsigned REQ_DEC = 1;

  // clocks per one-period step = 2^(base + per_code*code)
  function automatic int unsigned slew_log2(input logic [1:0] code,
                                            input int unsigned base,
                                            input int unsigned per_code);
    return base + per_code * int'(code);
  endfunction
endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ps_pulse_qual.sv
module ps_pulse_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic other_i,
  output logic valid_o
);
  logic prev_q, armed_q, armed_d;
  logic rise, fall;

  assign rise = req_i & ~prev_q;
  assign fall = ~req_i & prev_q;

  always_comb begin
    armed_d = armed_q;
    if (rise)                armed_d = ~other_i;
    else if (req_i & other_i) armed_d = 1'b0;
    else if (fall)           armed_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= req_i;
      armed_q <= armed_d;
    end
  end

  // accepted on the fall, opposite side still low
  assign valid_o = fall & armed_q & ~other_i;
endmodule

// File: rtl/ps_target.sv
module ps_target #(
  parameter int unsigned OFS_W = 12,
  parameter int unsigned STEP  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    inc_i,
  input  logic                    dec_i,
  input  logic                    hold_i,
  output logic signed [OFS_W-1:0] target_o
);
  localparam logic signed [OFS_W:0] HI  = {2'b00, {(OFS_W-1){1'b1}}};
  localparam logic signed [OFS_W:0] LO  = {2'b11, {(OFS_W-1){1'b0}}};
  localparam logic signed [OFS_W:0] STP = (OFS_W+1)'(STEP);

  logic signed [OFS_W-1:0] tgt_q;
  logic signed [OFS_W:0]   ext, sum;
  logic                    upd;

  assign ext = {tgt_q[OFS_W-1], tgt_q};
  assign upd = ~hold_i & (inc_i ^ dec_i);

  always_comb begin
    if (inc_i) sum = ext + STP;
    else       sum = ext - STP;
    if (sum > HI)      sum = HI;
    else if (sum < LO) sum = LO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  tgt_q <= '0;
    else if (upd) tgt_q <= sum[OFS_W-1:0];
  end

  assign target_o = tgt_q;
endmodule

// File: rtl/ps_slew.sv
module ps_slew #(
  parameter int unsigned OFS_W    = 12,
  parameter int unsigned BASE_LOG2 = 2,
  parameter int unsigned PER_CODE  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              bw_sel_i,
  input  logic signed [OFS_W-1:0] target_i,
  output logic signed [OFS_W-1:0] offset_o,
  output logic                    busy_o,
  output logic                    step_o
);
  import phase_slew_pkg::*;
  localparam int unsigned CW = BASE_LOG2 + PER_CODE * 3;

  logic signed [OFS_W-1:0] ofs_q;
  logic [CW-1:0]           cnt_q, lim;
  logic                    step_q, up;

  always_comb lim = CW'((1 << slew_log2(bw_sel_i, BASE_LOG2, PER_CODE)) - 1);

  assign busy_o = (ofs_q != target_i);
  assign up     = (target_i > ofs_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q  <= '0;
      cnt_q  <= '0;
      step_q <= 1'b0;
    end else if (!busy_o) begin
      cnt_q  <= '0;
      step_q <= 1'b0;
    end else if (cnt_q >= lim) begin
      // >= covers a code change to a shorter interval mid-count
      cnt_q  <= '0;
      step_q <= 1'b1;
      ofs_q  <= up ? ofs_q + 1'b1 : ofs_q - 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      step_q <= 1'b0;
    end
  end

  assign offset_o = ofs_q;
  assign step_o   = step_q;
endmodule

// File: rtl/phase_slew_ctrl.sv
module phase_slew_ctrl #(
  parameter int unsigned OFS_W     = 12,
  parameter int unsigned STEP      = 2,
  parameter int unsigned SYNC_N    = 2,
  parameter int unsigned BASE_LOG2 = 2,
  parameter int unsigned PER_CODE  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    inc_req_i,
  input  logic                    dec_req_i,
  input  logic                    hold_i,
  input  logic [1:0]              bw_sel_i,
  output logic signed [OFS_W-1:0] offset_o,
  output logic                    busy_o,
  output logic                    step_o
);
  import phase_slew_pkg::*;

  logic [REQ_N-1:0] req_raw, req_s, req_v;
  logic signed [OFS_W-1:0] target_q;

  assign req_raw[REQ_INC] = inc_req_i;
  assign req_raw[REQ_DEC] = dec_req_i;

  for (genvar g = 0; g < REQ_N; g++) begin : g_req
    ps_sync #(.STAGES(SYNC_N)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (req_raw[g]),
      .q_o   (req_s[g])
    );
    ps_pulse_qual u_qual (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req_s[g]),
      .other_i(req_s[REQ_N-1-g]),
      .valid_o(req_v[g])
    );
  end

  ps_target #(.OFS_W(OFS_W), .STEP(STEP)) u_target (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (req_v[REQ_INC]),
    .dec_i   (req_v[REQ_DEC]),
    .hold_i  (hold_i),
    .target_o(target_q)
  );

  ps_slew #(.OFS_W(OFS_W), .BASE_LOG2(BASE_LOG2), .PER_CODE(PER_CODE)) u_slew (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bw_sel_i(bw_sel_i),
    .target_i(target_q),
    .offset_o(offset_o),
    .busy_o  (busy_o),
    .step_o  (step_o)
  );
endmodule

// File: rtl/phase_slew_checker.sv
module phase_slew_checker #(
  parameter int unsigned OFS_W = 12
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    hold_i,
  input logic signed [OFS_W-1:0] offset_i,
  input logic signed [OFS_W-1:0] target_i,
  input logic                    busy_i,
  input logic                    step_i
);
  assert_step_unit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (int'(offset_i) - int'($past(offset_i)) == 1 ||
                int'(offset_i) - int'($past(offset_i)) == -1));

  assert_step_toward_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> ((offset_i > $past(offset_i)) == ($past(target_i) > $past(offset_i))));

  assert_still_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |-> offset_i == $past(offset_i));

  assert_step_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> $past(busy_i));

  assert_step_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> !step_i);

  assert_target_delta_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(target_i) - int'($past(target_i)) <= 2 &&
     int'(target_i) - int'($past(target_i)) >= -2));

  assert_hold_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(target_i));
endmodule

bind phase_slew_ctrl phase_slew_checker #(.OFS_W(OFS_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .hold_i  (hold_i),
  .offset_i(offset_o),
  .target_i(target_q),
  .busy_i  (busy_o),
  .step_i  (step_o)
);

// File: tb/sim_phase_slew_ctrl.sv
module sim_phase_slew_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic inc = 1'b0, dec = 1'b0, hold = 1'b0;
  logic [1:0] bw = 2'd0;
  logic signed [11:0] offset;
  logic busy, step;
  int checks = 0, fails = 0, exp_ofs = 0;

  always #5 clk = ~clk;

  phase_slew_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .inc_req_i(inc), .dec_req_i(dec),
    .hold_i(hold), .bw_sel_i(bw), .offset_o(offset), .busy_o(busy), .step_o(step)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit is_inc, input int hi);
    @(negedge clk);
    if (is_inc) inc = 1'b1; else dec = 1'b1;
    repeat (hi) @(negedge clk);
    inc = 1'b0; dec = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic settle(input int max);
    for (int i = 0; i < max && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(offset == 0, "R1 offset", offset, 0);
    check(busy == 0, "R1 busy", busy, 0);
    check(step == 0, "R1 step", step, 0);
  endtask

  task automatic t_inc_dec;
    bw = 2'd0;
    pulse(1, 3); settle(100); exp_ofs += 2;
    check(offset == exp_ofs, "R2 inc", offset, exp_ofs);
    pulse(0, 2); pulse(0, 5); settle(100); exp_ofs -= 4;
    check(offset == exp_ofs, "R3 dec", offset, exp_ofs);
  endtask

  task automatic t_whole_pulse;
    @(negedge clk); inc = 1'b1;
    repeat (20) @(negedge clk);
    check(busy == 0, "R5 held high busy", busy, 0);
    check(offset == exp_ofs, "R5 held high offset", offset, exp_ofs);
    inc = 1'b0; repeat (4) @(negedge clk); settle(100); exp_ofs += 2;
    check(offset == exp_ofs, "R5 after fall", offset, exp_ofs);
    // glitch high phase that no edge samples
    @(negedge clk); inc = 1'b1; #2 inc = 1'b0;
    repeat (10) @(negedge clk);
    check(busy == 0 && offset == exp_ofs, "R5 glitch", offset, exp_ofs);
  endtask

  task automatic t_overlap;
    @(negedge clk); inc = 1'b1;
    repeat (2) @(negedge clk); dec = 1'b1;
    repeat (2) @(negedge clk); inc = 1'b0;
    repeat (2) @(negedge clk); dec = 1'b0;
    repeat (10) @(negedge clk);
    check(busy == 0 && offset == exp_ofs, "R4 staggered overlap", offset, exp_ofs);
    @(negedge clk); dec = 1'b1;
    repeat (2) @(negedge clk); inc = 1'b1;
    repeat (2) @(negedge clk); inc = 1'b0;
    repeat (3) @(negedge clk); dec = 1'b0;
    repeat (10) @(negedge clk);
    check(busy == 0 && offset == exp_ofs, "R4 nested pulse", offset, exp_ofs);
  endtask

  task automatic t_hold;
    hold = 1'b1;
    pulse(1, 3); pulse(0, 3);
    repeat (10) @(negedge clk);
    check(busy == 0 && offset == exp_ofs, "R6 hold ignores", offset, exp_ofs);
    hold = 1'b0;
    pulse(1, 3); settle(100); exp_ofs += 2;
    check(offset == exp_ofs, "R6 after hold", offset, exp_ofs);
  endtask

  task automatic t_pace;
    for (int c = 0; c < 4; c++) begin
      int first, second, nsteps;
      bw = c[1:0];
      first = -1; second = -1; nsteps = 0;
      pulse(1, 2); exp_ofs += 2;
      for (int i = 0; i < 1200; i++) begin
        if (step) begin
          nsteps++;
          if (first < 0) first = i; else if (second < 0) second = i;
        end
        @(negedge clk);
      end
      check(second - first == (4 << (2 * c)), "R7 interval", second - first, 4 << (2 * c));
      check(nsteps == 2, "R7 step count", nsteps, 2);
      check(offset == exp_ofs, "R7 offset", offset, exp_ofs);
    end
  endtask

  task automatic t_during_slew;
    bw = 2'd3;
    pulse(1, 2);
    check(busy == 1, "R8 busy while slewing", busy, 1);
    pulse(1, 2); pulse(0, 2); pulse(1, 2);
    exp_ofs += 4;
    settle(3000);
    check(busy == 0, "R8 idle after slew", busy, 0);
    check(offset == exp_ofs, "R8 accumulated", offset, exp_ofs);
  endtask

  task automatic t_sat;
    bw = 2'd0;
    for (int i = 0; i < 1030; i++) pulse(1, 1);
    settle(20000);
    check(offset == 2047, "R9 upper limit", offset, 2047);
    for (int i = 0; i < 2050; i++) pulse(0, 1);
    settle(20000);
    check(offset == -2048, "R9 lower limit", offset, -2048);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_inc_dec();
    t_whole_pulse();
    t_overlap();
    t_hold();
    t_pace();
    t_during_slew();
    t_sat();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule